// File: doc/BRIEF.md
# Aging-Priority Multicast Output Arbiter

This block is the control half of an output crossbar in a shared-buffer switch element. Each buffer slot that receives a cell loads an output-select mask naming every output the cell must reach. Once per cell cycle, every output column independently chooses one of the slots that request it. A column contends only when the downstream stage grants that output. The winner is the slot whose cell has waited longest. Columns run side by side, so a multicast cell can leave on several outputs in the same cell cycle. Requests that lose stay in place and contend again in later cell cycles. When the last requested output of a slot has been served, the slot raises a one-cycle done pulse and is free for the next cell.

Each slot keeps a saturating age counter that starts at zero when the cell is loaded. The column finds the largest age with a bit-serial contest that runs from the most significant bit down, one bit per clock. At each bit, the contenders holding a 0 drop out whenever any contender holds a 1. One extra clock settles remaining ties toward the lowest slot index and registers the result. A cell cycle is therefore the age width plus one clock long. Moving the cell data is outside this block.

Top module: `mcast_age_arb`

## Requirements
- R1: While reset is asserted, out_valid and slot_done are all zero and cyc_start is 1 (phase 0).
- R2: A column samples its dn_grant bit only in the phase-0 clock of a cell cycle. When that bit is 0, the output shows no winner for that cell, and the requests for it stay pending.
- R3: Among the slots contending for an output, the one with the largest age wins.
- R4: Among contenders with equal age, the lowest slot index wins.
- R5: A slot's age is 0 when it is loaded. It rises by 1 at the end of every cell cycle in which the slot still has an unserved request. It saturates at 2^AGE_W-1 (63 by default).
- R6: A request that loses stays pending and contends again in every later cell cycle until it is served.
- R7: One slot can win several outputs in the same cell cycle. Each column decides on its own.
- R8: slot_done[s] pulses for exactly the phase-0 clock that follows the cell cycle in which slot s's last pending output was served. From then on the slot is free.
- R9: A load to a slot that still has pending requests is ignored. A load with an all-zero mask creates no request.
- R10: A load accepted in a cell cycle first contends in the next cell cycle.
- R11: A cell cycle lasts AGE_W+1 clocks (7 by default), and cyc_start is high in its first clock. out_valid and out_slot change only at cell-cycle boundaries and hold for the whole cell cycle.
- R12: Each output grants at most one slot per cell cycle, and only a slot that requests that output. Output o's winner index is out_slot[o*SLOT_W +: SLOT_W], and slot s's mask is req_sel[s*NUM_OUTS +: NUM_OUTS], with bit o selecting output o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_load | input | NUM_SLOTS | Per-slot load strobe for a new cell's mask |
| req_sel | input | NUM_SLOTS*NUM_OUTS | Per-slot output-select masks |
| dn_grant | input | NUM_OUTS | Downstream readiness, one bit per output |
| cyc_start | output | 1 | High in the first clock of each cell cycle |
| out_valid | output | NUM_OUTS | Output has a winner for this cell cycle |
| out_slot | output | NUM_OUTS*SLOT_W | Winning slot index per output |
| slot_done | output | NUM_SLOTS | One-clock pulse when a slot's fan-out is complete |

## Verification
Several properties are checked on every clock. The phase counter must wrap at its limit. A column's candidate set must stay a subset of the live requests, must only shrink during a contest, and must never become empty while requests remain. Each column serves at most one slot, and only a requesting one. Ages never fall while a request is pending, and outputs change only at cell boundaries. Which slot actually wins, the tie-break order, the effect of saturation, and the timing of done pulses against reloads depend on request history. Only the bench scenarios can show these, by comparing against a reference model of ages and pending masks.

// File: rtl/maa_pkg.sv
package maa_pkg;
    localparam int unsigned DEF_SLOTS = 40;
    localparam int unsigned DEF_OUTS  = 8;
    localparam int unsigned DEF_AGE_W = 6;
endpackage

// File: rtl/maa_phase.sv
module maa_phase #(
    parameter int unsigned AGE_W = maa_pkg::DEF_AGE_W,
    localparam int unsigned CYC_LEN = AGE_W + 1,
    localparam int unsigned PH_W = (CYC_LEN > 1) ? $clog2(CYC_LEN) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [PH_W-1:0] phase,
    output logic            first,
    output logic            last
);
    typedef struct packed {
        logic [PH_W-1:0] ph;
    } ph_state_t;

    ph_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.ph == PH_W'(CYC_LEN - 1)) s_d.ph = '0;
        else                              s_d.ph = s_q.ph + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign phase = s_q.ph;
    assign first = (s_q.ph == '0);
    assign last  = (s_q.ph == PH_W'(CYC_LEN - 1));

    p_phase_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.ph <= PH_W'(CYC_LEN - 1));
    p_phase_wrap_r11: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> first);
endmodule

// File: rtl/maa_slot.sv
module maa_slot #(
    parameter int unsigned NUM_OUTS = maa_pkg::DEF_OUTS,
    parameter int unsigned AGE_W    = maa_pkg::DEF_AGE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [NUM_OUTS-1:0] sel,
    input  logic                last,
    input  logic [NUM_OUTS-1:0] served,
    output logic [NUM_OUTS-1:0] pend,
    output logic [AGE_W-1:0]    age,
    output logic                done
);
    typedef struct packed {
        logic [NUM_OUTS-1:0] pend;
        logic [AGE_W-1:0]    age;
        logic                done;
    } slot_state_t;

    slot_state_t s_d, s_q;
    logic [NUM_OUTS-1:0] rem;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        rem      = s_q.pend & ~served;
        if (last && s_q.pend != '0) begin
            s_d.pend = rem;
            if (rem == '0)           s_d.done = 1'b1;
            else if (s_q.age != '1)  s_d.age  = s_q.age + 1'b1;
        end else if (load && s_q.pend == '0 && sel != '0) begin
            s_d.pend = sel;
            s_d.age  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pend = s_q.pend;
    assign age  = s_q.age;
    assign done = s_q.done;

    p_served_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (served & ~s_q.pend) == '0);
    p_age_mono_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.pend != '0) |=> (s_q.age >= $past(s_q.age)));
    p_done_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.done |-> (s_q.pend == '0));
    p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.pend != '0 && !last) |=> (s_q.pend == $past(s_q.pend)));
endmodule

// File: rtl/maa_column.sv
module maa_column #(
    parameter int unsigned NUM_SLOTS = maa_pkg::DEF_SLOTS,
    localparam int unsigned SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 first,
    input  logic                 last,
    input  logic                 grant,
    input  logic [NUM_SLOTS-1:0] req,
    input  logic [NUM_SLOTS-1:0] bitv,
    output logic [NUM_SLOTS-1:0] serve,
    output logic                 out_valid,
    output logic [SLOT_W-1:0]    out_slot
);
    typedef struct packed {
        logic [NUM_SLOTS-1:0] cand;
        logic                 vld;
        logic [SLOT_W-1:0]    slot;
    } col_state_t;

    col_state_t s_d, s_q;
    logic [NUM_SLOTS-1:0] base, hit;
    logic                 found;
    logic [SLOT_W-1:0]    idx;

    always_comb begin
        s_d   = s_q;
        serve = '0;
        found = 1'b0;
        idx   = '0;
        base  = first ? (grant ? req : '0) : s_q.cand;
        hit   = base & bitv;
        if (!last) begin
            s_d.cand = (hit != '0) ? hit : base;
        end else begin
            for (int s = 0; s < int'(NUM_SLOTS); s++) begin
                if (!found && s_q.cand[s]) begin
                    found = 1'b1;
                    idx   = SLOT_W'(s);
                end
            end
            if (found) serve[idx] = 1'b1;
            s_d.vld  = found;
            s_d.slot = found ? idx : '0;
            s_d.cand = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign out_valid = s_q.vld;
    assign out_slot  = s_q.slot;

    p_cand_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.cand & ~req) == '0);
    p_cand_shrink_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!first && !$past(first) && !$past(last)) |-> ((s_q.cand & ~$past(s_q.cand)) == '0));
    p_cand_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!first && !$past(first) && !$past(last) && $past(s_q.cand) != '0) |-> (s_q.cand != '0));
    p_serve_one_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(serve));
    p_grant_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (first && !grant) |=> (s_q.cand == '0));
endmodule

// File: rtl/mcast_age_arb.sv
module mcast_age_arb #(
    parameter int unsigned NUM_SLOTS = maa_pkg::DEF_SLOTS,
    parameter int unsigned NUM_OUTS  = maa_pkg::DEF_OUTS,
    parameter int unsigned AGE_W     = maa_pkg::DEF_AGE_W,
    localparam int unsigned SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
    localparam int unsigned CYC_LEN = AGE_W + 1,
    localparam int unsigned PH_W = (CYC_LEN > 1) ? $clog2(CYC_LEN) : 1,
    localparam int unsigned AI_W = (AGE_W > 1) ? $clog2(AGE_W) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_SLOTS-1:0]          req_load,
    input  logic [NUM_SLOTS*NUM_OUTS-1:0] req_sel,
    input  logic [NUM_OUTS-1:0]           dn_grant,
    output logic                          cyc_start,
    output logic [NUM_OUTS-1:0]           out_valid,
    output logic [NUM_OUTS*SLOT_W-1:0]    out_slot,
    output logic [NUM_SLOTS-1:0]          slot_done
);
    logic [PH_W-1:0]      phase;
    logic                 first, last;
    logic [NUM_OUTS-1:0]  slot_pend [NUM_SLOTS];
    logic [AGE_W-1:0]     slot_age  [NUM_SLOTS];
    logic [NUM_OUTS-1:0]  slot_srv  [NUM_SLOTS];
    logic [NUM_SLOTS-1:0] col_req   [NUM_OUTS];
    logic [NUM_SLOTS-1:0] col_serve [NUM_OUTS];
    logic [NUM_SLOTS-1:0] bitv;
    int                   bi;

    maa_phase #(.AGE_W(AGE_W)) u_phase (
        .clk(clk), .rst_n(rst_n), .phase(phase), .first(first), .last(last)
    );

    // current contest bit, MSB first
    always_comb begin
        bi   = int'(AGE_W) - 1 - int'(phase);
        bitv = '0;
        for (int s = 0; s < int'(NUM_SLOTS); s++) begin
            if (bi >= 0) bitv[s] = slot_age[s][AI_W'(bi)];
        end
    end

    always_comb begin
        for (int o = 0; o < int'(NUM_OUTS); o++) begin
            for (int s = 0; s < int'(NUM_SLOTS); s++) begin
                col_req[o][s]  = slot_pend[s][o];
                slot_srv[s][o] = col_serve[o][s];
            end
        end
    end

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        maa_slot #(.NUM_OUTS(NUM_OUTS), .AGE_W(AGE_W)) u_slot (
            .clk(clk), .rst_n(rst_n),
            .load(req_load[s]),
            .sel(req_sel[s*NUM_OUTS +: NUM_OUTS]),
            .last(last),
            .served(slot_srv[s]),
            .pend(slot_pend[s]),
            .age(slot_age[s]),
            .done(slot_done[s])
        );
    end

    for (genvar o = 0; o < NUM_OUTS; o++) begin : g_col
        maa_column #(.NUM_SLOTS(NUM_SLOTS)) u_col (
            .clk(clk), .rst_n(rst_n),
            .first(first), .last(last),
            .grant(dn_grant[o]),
            .req(col_req[o]),
            .bitv(bitv),
            .serve(col_serve[o]),
            .out_valid(out_valid[o]),
            .out_slot(out_slot[o*SLOT_W +: SLOT_W])
        );
    end

    assign cyc_start = first;

    p_out_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !first |-> ($stable(out_valid) && $stable(out_slot)));
    p_done_boundary_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_done != '0) |-> first);
endmodule

// File: tb/mcast_age_arb_test.sv
module mcast_age_arb_test;
    localparam int NS    = 40;
    localparam int NO    = 8;
    localparam int AW    = 6;
    localparam int SW    = 6;
    localparam int CYC   = AW + 1;
    localparam int AMAX  = (1 << AW) - 1;
    localparam int CLK_P = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NS-1:0]    req_load = '0;
    logic [NS*NO-1:0] req_sel = '0;
    logic [NO-1:0]    dn_grant = '0;
    logic             cyc_start;
    logic [NO-1:0]    out_valid;
    logic [NO*SW-1:0] out_slot;
    logic [NS-1:0]    slot_done;

    always #(CLK_P/2) clk = ~clk;

    mcast_age_arb uut (
        .clk(clk), .rst_n(rst_n), .req_load(req_load), .req_sel(req_sel),
        .dn_grant(dn_grant), .cyc_start(cyc_start), .out_valid(out_valid),
        .out_slot(out_slot), .slot_done(slot_done)
    );

    typedef struct {
        logic [NO-1:0]    v;
        logic [NO*SW-1:0] sl;
        logic [NS-1:0]    dn;
        string            tag;
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int errs = 0;
    logic [NO-1:0] m_pend [NS];
    int            m_age  [NS];
    logic [NS-1:0]    ld_v = '0;
    logic [NS*NO-1:0] ld_s = '0;

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: %s actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    function automatic void ld(input int s, input logic [NO-1:0] m);
        ld_v[s] = 1'b1;
        ld_s[s*NO +: NO] = m;
    endfunction

    // monitor: compares each finished cell against the scoreboard
    always @(posedge clk) begin : mon
        exp_t e;
        #(CLK_P/4);
        if (rst_n && cyc_start && q.size() > 0) begin
            e = q.pop_front();
            chk(out_valid == e.v, {e.tag, "/R12"}, "out_valid", out_valid, e.v);
            for (int o = 0; o < NO; o++) begin
                if (e.v[o])
                    chk(out_slot[o*SW +: SW] == e.sl[o*SW +: SW], e.tag,
                        $sformatf("out_slot[%0d]", o), out_slot[o*SW +: SW], e.sl[o*SW +: SW]);
            end
            chk(slot_done == e.dn, {e.tag, "/R8"}, "slot_done", slot_done, e.dn);
        end
    end

    task automatic wait_start();
        do @(negedge clk); while (!cyc_start);
    endtask

    // driver: applies one cell of stimulus and pushes the expected result
    task automatic drive_cell(input logic [NO-1:0] g, input string tag);
        exp_t e;
        int best [NO];
        bit was_busy [NS];
        wait_start();
        dn_grant = g;
        req_load = ld_v;
        req_sel  = ld_s;
        e.v = '0; e.sl = '0; e.dn = '0; e.tag = tag;
        for (int o = 0; o < NO; o++) begin
            best[o] = -1;
            for (int s = 0; s < NS; s++)
                if (m_pend[s][o] && g[o] && (best[o] < 0 || m_age[s] > m_age[best[o]]))
                    best[o] = s;
            if (best[o] >= 0) begin
                e.v[o] = 1'b1;
                e.sl[o*SW +: SW] = SW'(best[o]);
            end
        end
        for (int s = 0; s < NS; s++) was_busy[s] = (m_pend[s] != '0);
        for (int s = 0; s < NS; s++)
            if (ld_v[s] && !was_busy[s] && ld_s[s*NO +: NO] != '0) begin
                m_pend[s] = ld_s[s*NO +: NO];
                m_age[s]  = 0;
            end
        for (int o = 0; o < NO; o++)
            if (best[o] >= 0) m_pend[best[o]][o] = 1'b0;
        for (int s = 0; s < NS; s++) begin
            if (was_busy[s] && m_pend[s] == '0) e.dn[s] = 1'b1;
            if (m_pend[s] != '0 && m_age[s] < AMAX) m_age[s]++;
        end
        q.push_back(e);
        @(negedge clk);
        req_load = '0;
        req_sel  = '0;
        ld_v = '0;
        ld_s = '0;
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: run hung actual=%0d expected=%0d", 200000, 0);
        report();
        $finish;
    end

    initial begin : main
        int t0;
        logic [NO-1:0] v_mid;
        for (int s = 0; s < NS; s++) begin m_pend[s] = '0; m_age[s] = 0; end
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(out_valid == '0, "R1", "out_valid in reset", out_valid, 0);
        chk(slot_done == '0, "R1", "slot_done in reset", slot_done, 0);
        chk(cyc_start == 1'b1, "R1", "cyc_start in reset", cyc_start, 1);
        rst_n = 1'b1;

        // R10: loads join next cell; R7/R4 multicast + tie; R6 retry
        ld(3, 8'h05); ld(7, 8'h01);
        drive_cell(8'hFF, "R10");
        drive_cell(8'hFF, "R7");
        drive_cell(8'hFF, "R6");

        // R2 grant gating, R9 busy reload ignored, R3 oldest wins
        ld(10, 8'h10);
        drive_cell(8'hEF, "R2");
        ld(10, 8'h01);
        drive_cell(8'hEF, "R9");
        ld(2, 8'h10);
        drive_cell(8'hEF, "R2");
        drive_cell(8'hFF, "R3");
        drive_cell(8'hFF, "R6");

        // R9 empty mask creates nothing
        ld(30, 8'h00);
        drive_cell(8'hFF, "R9");
        drive_cell(8'hFF, "R9");

        // R11 cell period and output stability
        wait_start();
        t0 = 0;
        v_mid = out_valid;
        do begin @(negedge clk); t0++; end while (!cyc_start);
        chk(t0 == CYC, "R11", "cell cycle length", t0, CYC);
        repeat (3) @(negedge clk);
        chk(out_valid == v_mid, "R11", "out_valid mid-cell", out_valid, v_mid);

        // R5 saturation then R4 tie at the ceiling
        ld(20, 8'h02);
        drive_cell(8'hFD, "R5");
        for (int i = 0; i < 4; i++) drive_cell(8'hFD, "R5");
        ld(15, 8'h02);
        for (int i = 0; i < 70; i++) drive_cell(8'hFD, "R5");
        drive_cell(8'hFF, "R5");
        drive_cell(8'hFF, "R4");

        // mixed traffic
        for (int c = 0; c < 60; c++) begin
            int n;
            n = int'($urandom_range(0, 3));
            for (int k = 0; k < n; k++)
                ld(int'($urandom_range(0, NS-1)), NO'($urandom));
            drive_cell(NO'($urandom) | NO'($urandom), "R6");
        end
        for (int c = 0; c < 12; c++) drive_cell(8'hFF, "R8");
        wait_start();
        @(negedge clk);
        chk(q.size() == 0, "R8", "scoreboard drained", q.size(), 0);
        report();
        $finish;
    end
endmodule